// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block supervises a processor from inside a digital design. It holds the processor in reset while an external, already synchronized supply-low flag is raised. After the flag clears it keeps reset asserted for a fixed stretch time. A watchdog also watches a kick input that the processor toggles. If the toggling stops for longer than the chosen timeout, the watchdog starts the same stretched reset pulse. A status output goes low on each timeout, so software can tell a watchdog reset from a supply reset.

All times are counted in ticks of one prescaler that divides the system clock by a parameter. The default tick is 1 ms at 50 MHz. The timeout is chosen between a short and a long period. The long period is always used for the first timeout after any reset. The short period takes effect only once the processor has produced its first kick edge after reset ends. Clearing the enable input stands for a floating kick pin and turns the watchdog off.

Top module: `wds_supervisor`

## Requirements
- R1: While `supply_low_i` is 1, `rst_n_o` is 0 from the second clock edge after it is sampled high, and it stays 0 for as long as the flag is held.
- R2: When the supply flag clears, reset stays asserted for STRETCH_TICKS ticks before it is released. The same stretch follows the release of the synchronous `rst` input. With a tick of TICK_DIV cycles, the release lands between (STRETCH_TICKS-1)*TICK_DIV and STRETCH_TICKS*TICK_DIV+2 cycles after the cause clears.
- R3: `rst_o` is always the bitwise complement of `rst_n_o`.
- R4: After the first kick edge, the timeout is SHORT_TICKS when `short_sel_i` is 1 and LONG_TICKS when it is 0.
- R5: The first timeout after any reset ends is LONG_TICKS, whatever the value of `short_sel_i`.
- R6: The short period applies only after a kick edge that arrives once reset has gone inactive.
- R7: A rising edge and a falling edge of `kick_i` both restart the timeout count. The edge reaches the counter three clock edges after the input changes, because of a two-flop synchronizer and an edge register.
- R8: The watchdog count restarts when reset ends. If `kick_i` is held constant, a reset pulse recurs after every LONG_TICKS timeout.
- R9: A watchdog timeout produces a reset pulse of STRETCH_TICKS ticks.
- R10: `wdog_ok_o` goes to 0 on a timeout and returns to 1 on the next kick edge. It is held at 1 while `supply_low_i` is 1, and it is 1 after `rst`.
- R11: While `wd_en_i` is 0, no timeout occurs, no watchdog reset is issued, and `wdog_ok_o` does not fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low_i | input | 1 | Synchronized supply-low flag from the comparator |
| kick_i | input | 1 | Watchdog kick; either edge restarts the timeout |
| short_sel_i | input | 1 | 1 selects the short period, 0 the long period |
| wd_en_i | input | 1 | 1 enables the watchdog |
| rst_n_o | output | 1 | Active-low processor reset (registered) |
| rst_o | output | 1 | Active-high processor reset (registered) |
| wdog_ok_o | output | 1 | 0 after a timeout until the next kick edge |

## Verification
The design is built with a four-cycle tick and periods of 5, 8 and 20 ticks. Every measured interval is compared with a window computed from these numbers. Runs with no kicks at all separate the forced long first period from the short period, and they show that the pulses recur. The bench then sweeps select values, kick polarities and kick delays after release. This shows that either edge restarts the count and that the select input only acts after a kick. A steady fast kick train, a long supply-low hold and a disabled-watchdog run check that the supply flag has priority and that no spurious reset is issued.

// File: rtl/wds_pkg.sv
package wds_pkg;
  function automatic int cw(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wds_prescaler.sv
module wds_prescaler #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = wds_pkg::cw(TICK_DIV);
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_q == LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/wds_kick_sync.sv
module wds_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], kick_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wds_stretch.sv
module wds_stretch #(
  parameter int STRETCH_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic fire_i,
  output logic active_o
);
  localparam int SW = wds_pkg::cw(STRETCH_TICKS);
  localparam logic [SW-1:0] SEND = SW'(STRETCH_TICKS - 1);

  logic [SW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst || supply_low_i || fire_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && tick_i) begin
      if (cnt_q == SEND) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = act_q;

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low_i |=> act_q);
  // R2
  no_early_release_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !(tick_i && cnt_q == SEND)) |=> act_q);
  // R9
  fire_starts_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> (act_q && cnt_q == '0));
endmodule

// File: rtl/wds_watchdog.sv
module wds_watchdog #(
  parameter int SHORT_TICKS = 100,
  parameter int LONG_TICKS  = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic kick_edge_i,
  input  logic in_reset_i,
  input  logic supply_low_i,
  input  logic short_sel_i,
  input  logic en_i,
  output logic fire_o,
  output logic ok_o
);
  localparam int TW = wds_pkg::cw(LONG_TICKS);
  localparam logic [TW-1:0] S_END = TW'(SHORT_TICKS - 1);
  localparam logic [TW-1:0] L_END = TW'(LONG_TICKS - 1);

  logic [TW-1:0] cnt_q;
  logic          first_q;
  logic          ok_q;
  logic [TW-1:0] lim_end;

  always_comb begin
    lim_end = (first_q || !short_sel_i) ? L_END : S_END;
  end

  assign fire_o = en_i && !in_reset_i && tick_i && (cnt_q == lim_end);

  always_ff @(posedge clk) begin
    if (rst || in_reset_i) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (kick_edge_i) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (!en_i || fire_o) begin
      cnt_q   <= '0;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || supply_low_i) ok_q <= 1'b1;
    else if (fire_o)         ok_q <= 1'b0;
    else if (kick_edge_i)    ok_q <= 1'b1;
  end

  assign ok_o = ok_q;

  // R5
  long_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    in_reset_i |=> first_q);
  // R7
  kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (kick_edge_i && !in_reset_i) |=> (cnt_q == '0 && !first_q));
  // R10
  ok_forced_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low_i |=> ok_q);
  // R10
  ok_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_o && !supply_low_i) |=> !ok_q);
  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> !fire_o);
endmodule

// File: rtl/wds_supervisor.sv
module wds_supervisor #(
  parameter int TICK_DIV      = 50000,
  parameter int STRETCH_TICKS = 200,
  parameter int SHORT_TICKS   = 100,
  parameter int LONG_TICKS    = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low_i,
  input  logic kick_i,
  input  logic short_sel_i,
  input  logic wd_en_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic wdog_ok_o
);
  logic tick;
  logic kick_edge;
  logic fire;
  logic in_rst;

  wds_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick));

  wds_kick_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .kick_i(kick_i), .edge_o(kick_edge));

  wds_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
    .clk(clk), .rst(rst), .tick_i(tick), .supply_low_i(supply_low_i),
    .fire_i(fire), .active_o(in_rst));

  wds_watchdog #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_wd (
    .clk(clk), .rst(rst), .tick_i(tick), .kick_edge_i(kick_edge),
    .in_reset_i(in_rst), .supply_low_i(supply_low_i),
    .short_sel_i(short_sel_i), .en_i(wd_en_i),
    .fire_o(fire), .ok_o(wdog_ok_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b0;
      rst_o   <= 1'b1;
    end else begin
      rst_n_o <= ~in_rst;
      rst_o   <= in_rst;
    end
  end

  // R3
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    rst_n_o != rst_o);
  // R1
  out_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_rst |=> !rst_n_o);
endmodule

// File: tb/wds_supervisor_bench.sv
module wds_supervisor_bench;
  localparam int D = 4;
  localparam int N = 5;
  localparam int S = 8;
  localparam int L = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0, kick = 1'b0, sel = 1'b1, en = 1'b1;
  logic rst_n, rst_h, ok;

  int checks = 0, fails = 0, comp_bad = 0;

  always #10 clk = ~clk;

  wds_supervisor #(.TICK_DIV(D), .STRETCH_TICKS(N), .SHORT_TICKS(S),
                   .LONG_TICKS(L)) u_wds_supervisor (
    .clk(clk), .rst(rst), .supply_low_i(supply_low), .kick_i(kick),
    .short_sel_i(sel), .wd_en_i(en), .rst_n_o(rst_n), .rst_o(rst_h),
    .wdog_ok_o(ok));

  always @(negedge clk) if (!rst && rst_n === rst_h) comp_bad++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int v, input int lo, input int hi);
    checks++;
    if (v < lo || v > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, v, lo, hi);
    end
  endtask

  task automatic wait_lvl(input logic lvl, output int n);
    n = 0;
    while (rst_n !== lvl && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle_lows(input int cyc, output int lows);
    lows = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (rst_n !== 1'b1) lows++;
    end
  endtask

  initial begin
    int n, lows, okdrops;
    repeat (3) @(negedge clk);
    chk("R3 reset rst_n", int'(rst_n), 0);
    chk("R3 reset rst_o", int'(rst_h), 1);
    chk("R10 reset ok", int'(ok), 1);
    rst = 1'b0;
    wait_lvl(1'b1, n);
    chk_rng("R2 power-up stretch", n, (N-1)*D, N*D+2);

    wait_lvl(1'b0, n);
    chk_rng("R5 first timeout long with short select", n, (L-1)*D, L*D+4);
    chk("R10 ok low on timeout", int'(ok), 0);
    wait_lvl(1'b1, n);
    chk_rng("R9 watchdog pulse width", n, (N-1)*D, N*D+2);
    wait_lvl(1'b0, n);
    chk_rng("R8 recurring long timeout", n, (L-1)*D, L*D+4);
    wait_lvl(1'b1, n);
    chk_rng("R9 second pulse width", n, (N-1)*D, N*D+2);
    chk("R10 ok stays low without kick", int'(ok), 0);

    kick = ~kick;
    repeat (4) @(negedge clk);
    chk("R10 ok back high on kick", int'(ok), 1);
    wait_lvl(1'b0, n);
    chk_rng("R6 short period after first kick", n + 4, (S-1)*D, S*D+6);
    wait_lvl(1'b1, n);

    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 4; d++) begin
        sel = s[0];
        repeat (d * 13) @(negedge clk);
        kick = ~kick;
        @(negedge clk);
        wait_lvl(1'b0, n);
        if (s == 1) chk_rng("R4 R7 short sweep", n + 1, (S-1)*D, S*D+6);
        else        chk_rng("R4 R7 long sweep", n + 1, (L-1)*D, L*D+6);
        wait_lvl(1'b1, n);
      end
    end

    sel = 1'b1;
    lows = 0;
    for (int k = 0; k < 20; k++) begin
      int t;
      idle_lows(16, t);
      lows += t;
      kick = ~kick;
    end
    chk("R7 steady kicks keep reset off", lows, 0);

    supply_low = 1'b1;
    repeat (2) @(negedge clk);
    lows = 0;
    okdrops = 0;
    for (int i = 0; i < 100; i++) begin
      if (rst_n !== 1'b0) lows++;
      if (ok !== 1'b1) okdrops++;
      @(negedge clk);
    end
    chk("R1 reset held under supply low", lows, 0);
    chk("R10 ok forced high under supply low", okdrops, 0);
    supply_low = 1'b0;
    wait_lvl(1'b1, n);
    chk_rng("R2 supply recovery stretch", n, (N-1)*D, N*D+2);

    en = 1'b0;
    okdrops = 0;
    lows = 0;
    for (int i = 0; i < 3*L*D; i++) begin
      @(negedge clk);
      if (rst_n !== 1'b1) lows++;
      if (ok !== 1'b1) okdrops++;
    end
    chk("R11 disabled no reset", lows, 0);
    chk("R11 disabled ok steady", okdrops, 0);
    en = 1'b1;
    wait_lvl(1'b0, n);
    chk_rng("R11 R5 re-enabled long timeout", n, (L-1)*D, L*D+6);
    wait_lvl(1'b1, n);

    chk("R3 complement every cycle", comp_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule